// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

The sequencer watches single-bit match strobes that comparison units elsewhere produce, and declares a trigger only after a programmed series of conditions has been met in order. Each level of the series holds a select code that names the strobe it waits for. When that strobe is high in a cycle, the sequencer steps to the next level. When the last level is satisfied, it enters a fired state that a capture controller can observe. This catches ordered bus events, such as a valid strobe followed later by an acknowledge edge, while ignoring the same events when they arrive in the wrong order.

A user trigger-in bus of build-time width can be folded in as one more strobe: any high bit on it counts as a hit. The number of levels is set at build time. With zero levels, no sequence is built and the block fires on the OR of every source. A registered, single-cycle trigger-out pulse for other cores or an external pin is built only when a build-time flag asks for it. The sequencer stays fired until it is re-armed.

Top module: `trgseq_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, level_o is 0 and trig_o, trig_pulse_o and trig_out_o are low, with the sequencer armed.
- R2: Source index i < NUM_MATCH is match_i[i]. The current level advances only in a cycle where the source named by its select field is high. The select field of level k is lvl_sel_i[k*SEL_W +: SEL_W]. High strobes on any other source leave the level unchanged.
- R3: The level advances by at most one step per clock, even when the strobes for several consecutive levels are high in the same cycle.
- R4: A strobe belonging to a later level that arrives while an earlier level is still waiting does not count. The trigger requires the levels' strobes in order.
- R5: If the last level's strobe is high while armed, trig_o rises on the next cycle and trig_pulse_o is high for exactly that one cycle.
- R6: With TRIG_OUT_EN = 1, trig_out_o is a registered pulse in the same cycle as trig_pulse_o. With TRIG_OUT_EN = 0, trig_out_o is always low.
- R7: While fired, every strobe is ignored: trig_o stays high, level_o does not change and no further pulse is issued.
- R8: arm_i returns level_o to 0 and clears trig_o on the next cycle. It takes priority over any strobe in the same cycle, including the one that would finish the sequence.
- R9: When TRIG_IN_W > 0, source index NUM_MATCH is the OR of all trig_in_i bits, so any single high bit is a hit.
- R10: A select code at or above the number of sources (NUM_MATCH, plus one if TRIG_IN_W > 0) never matches, so that level never advances.
- R11: With LEVELS = 0, the block fires on the cycle after any source is high, with the same fired-state, pulse and arm behaviour as above, and level_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Re-arm: return to level 0 and leave the fired state |
| match_i | input | NUM_MATCH | Match strobes from the comparison units |
| trig_in_i | input | max(1,TRIG_IN_W) | User trigger-in bus; any high bit is a hit (unused when TRIG_IN_W = 0) |
| lvl_sel_i | input | max(1,LEVELS)*SEL_W | Per-level source select codes, level k at bits k*SEL_W |
| level_o | output | LVL_W | Current level |
| trig_o | output | 1 | Fired state, held until re-arm |
| trig_pulse_o | output | 1 | One-cycle trigger event to the capture controller |
| trig_out_o | output | 1 | Optional registered trigger-out pulse |

## Verification
The case where two functions share a cycle is a re-arm that lands in the same cycle as the strobe that would complete the final level. The bench provokes it by walking the sequence up to the last level, then raising arm_i together with a trigger-in bit. It judges the result by requiring level_o = 0 with trig_o, trig_pulse_o and trig_out_o all low on the next cycle. A second overlap, two consecutive levels' strobes in one cycle, is judged by requiring a single level step.

// File: rtl/trgseq_pkg.sv
package trgseq_pkg;

  typedef enum logic {
    SEQ_ARMED = 1'b0,
    SEQ_FIRED = 1'b1
  } seq_state_e;

  // At least one, so that zero-sized build options still give legal vectors.
  function automatic int unsigned at_least_one(int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

  // Bits needed to count 0 .. n-1, never below one.
  function automatic int unsigned index_bits(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/trgseq_src_merge.sv
module trgseq_src_merge #(
  parameter int unsigned NUM_MATCH = 4,
  parameter int unsigned TRIG_IN_W = 8,
  parameter int unsigned TI_W      = 8,
  parameter int unsigned NSRC      = 5
) (
  input  logic [NUM_MATCH-1:0] match_i,
  input  logic [TI_W-1:0]      trig_in_i,
  output logic [NSRC-1:0]      src_o
);

  generate
    if (TRIG_IN_W > 0) begin : g_with_tin
      logic tin_any;
      assign tin_any = |trig_in_i;
      assign src_o   = {tin_any, match_i};
    end else begin : g_no_tin
      logic tin_unused;
      assign tin_unused = ^trig_in_i;
      assign src_o      = match_i;
    end
  endgenerate

endmodule

// File: rtl/trgseq_level_fsm.sv
module trgseq_level_fsm
  import trgseq_pkg::*;
#(
  parameter int unsigned LEVELS = 3,
  parameter int unsigned NSRC   = 5,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned LV_EFF = 3,
  parameter int unsigned LVL_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    arm_i,
  input  logic [NSRC-1:0]         src_i,
  input  logic [LV_EFF*SEL_W-1:0] sel_i,
  output logic [LVL_W-1:0]        lvl_o,
  output logic                    fired_o,
  output logic                    pulse_o,
  output logic                    fire_now_o
);

  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LV_EFF - 1);

  // Returns the strobe named by idx; a code past the last source yields 0.
  function automatic logic pick_src(logic [NSRC-1:0] s, logic [SEL_W-1:0] idx);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (idx == SEL_W'(i)) r = s[i];
    end
    return r;
  endfunction

  seq_state_e       state_q;
  logic [LVL_W-1:0] lvl_q;
  logic             pulse_q;
  logic             hit;
  logic             at_last;
  logic             armed;
  logic             advance;
  logic             fire_now;

  generate
    if (LEVELS == 0) begin : g_direct
      logic sel_unused;
      assign sel_unused = ^sel_i;
      assign hit        = |src_i;
      assign at_last    = 1'b1;
    end else begin : g_seq
      logic [SEL_W-1:0] cur_sel;
      assign cur_sel = sel_i[lvl_q*SEL_W +: SEL_W];
      assign hit     = pick_src(src_i, cur_sel);
      assign at_last = (lvl_q == LAST_LVL);
    end
  endgenerate

  assign armed    = (state_q == SEQ_ARMED);
  assign advance  = armed && !arm_i && hit && !at_last;
  assign fire_now = armed && !arm_i && hit && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_ARMED;
      lvl_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire_now;
      if (arm_i) begin
        state_q <= SEQ_ARMED;
        lvl_q   <= '0;
      end else if (fire_now) begin
        state_q <= SEQ_FIRED;
      end else if (advance) begin
        lvl_q <= lvl_q + 1'b1;
      end
    end
  end

  assign lvl_o      = lvl_q;
  assign fired_o    = (state_q == SEQ_FIRED);
  assign pulse_o    = pulse_q;
  assign fire_now_o = fire_now;

  // R3
  one_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> ((lvl_q == $past(lvl_q)) || (lvl_q == $past(lvl_q) + 1'b1)));

  // R5
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);

  // R5
  pulse_from_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> (fired_o && (lvl_q == LAST_LVL)));

  // R7
  fired_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_o && !arm_i) |=> (fired_o && $stable(lvl_q) && !pulse_q));

  // R8
  arm_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (!fired_o && (lvl_q == '0) && !pulse_q));

endmodule

// File: rtl/trgseq_trig_out.sv
module trgseq_trig_out #(
  parameter bit TRIG_OUT_EN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_now_i,
  input  logic pulse_i,
  output logic trig_out_o
);

  generate
    if (TRIG_OUT_EN) begin : g_out
      logic out_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= 1'b0;
        else         out_q <= fire_now_i;
      end
      assign trig_out_o = out_q;

      // R6
      out_tracks_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_out_o == pulse_i);
    end else begin : g_none
      logic unused_in;
      assign unused_in  = fire_now_i ^ pulse_i;
      assign trig_out_o = 1'b0;

      // R6
      out_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trig_out_o);
    end
  endgenerate

endmodule

// File: rtl/trgseq_top.sv
module trgseq_top
  import trgseq_pkg::*;
#(
  parameter int unsigned NUM_MATCH   = 4,
  parameter int unsigned TRIG_IN_W   = 8,
  parameter int unsigned LEVELS      = 3,
  parameter bit          TRIG_OUT_EN = 1'b1,
  localparam int unsigned TI_W   = at_least_one(TRIG_IN_W),
  localparam int unsigned NSRC   = NUM_MATCH + ((TRIG_IN_W > 0) ? 1 : 0),
  localparam int unsigned SEL_W  = $clog2(NSRC + 1),
  localparam int unsigned LV_EFF = at_least_one(LEVELS),
  localparam int unsigned LVL_W  = index_bits(LV_EFF)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    arm_i,
  input  logic [NUM_MATCH-1:0]    match_i,
  input  logic [TI_W-1:0]         trig_in_i,
  input  logic [LV_EFF*SEL_W-1:0] lvl_sel_i,
  output logic [LVL_W-1:0]        level_o,
  output logic                    trig_o,
  output logic                    trig_pulse_o,
  output logic                    trig_out_o
);

  logic [NSRC-1:0] src;
  logic            fire_now;
  logic            pulse;

  trgseq_src_merge #(
    .NUM_MATCH (NUM_MATCH),
    .TRIG_IN_W (TRIG_IN_W),
    .TI_W      (TI_W),
    .NSRC      (NSRC)
  ) u_merge (
    .match_i   (match_i),
    .trig_in_i (trig_in_i),
    .src_o     (src)
  );

  trgseq_level_fsm #(
    .LEVELS (LEVELS),
    .NSRC   (NSRC),
    .SEL_W  (SEL_W),
    .LV_EFF (LV_EFF),
    .LVL_W  (LVL_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm_i),
    .src_i      (src),
    .sel_i      (lvl_sel_i),
    .lvl_o      (level_o),
    .fired_o    (trig_o),
    .pulse_o    (pulse),
    .fire_now_o (fire_now)
  );

  trgseq_trig_out #(
    .TRIG_OUT_EN (TRIG_OUT_EN)
  ) u_tout (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_now_i (fire_now),
    .pulse_i    (pulse),
    .trig_out_o (trig_out_o)
  );

  assign trig_pulse_o = pulse;

  // R11
  direct_level_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LEVELS == 0) |-> (level_o == '0));

endmodule

// File: tb/trgseq_top_tb.sv
module trgseq_top_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm = 1'b0;
  logic [3:0] match = '0;
  logic [7:0] tin = '0;
  logic [8:0] sel = '0;
  logic [1:0] lvl;
  logic       trig, pulse, tout;

  logic       d_arm = 1'b0;
  logic [3:0] d_match = '0;
  logic [0:0] d_lvl;
  logic       d_trig, d_pulse, d_tout;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trgseq_top #(.NUM_MATCH(4), .TRIG_IN_W(8), .LEVELS(3), .TRIG_OUT_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .match_i(match), .trig_in_i(tin),
    .lvl_sel_i(sel), .level_o(lvl), .trig_o(trig), .trig_pulse_o(pulse), .trig_out_o(tout)
  );

  trgseq_top #(.NUM_MATCH(4), .TRIG_IN_W(0), .LEVELS(0), .TRIG_OUT_EN(1'b0)) u_dut_direct (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(d_arm), .match_i(d_match), .trig_in_i(1'b0),
    .lvl_sel_i(3'd0), .level_o(d_lvl), .trig_o(d_trig), .trig_pulse_o(d_pulse),
    .trig_out_o(d_tout)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_main(input string tag, input int e_lvl, input int e_trig, input int e_pulse);
    check(tag, "level_o", lvl, e_lvl);
    check(tag, "trig_o", trig, e_trig);
    check(tag, "trig_pulse_o", pulse, e_pulse);
    check(tag, "trig_out_o", tout, e_pulse);
  endtask

  // {match[3:0], tin[7:0], arm, exp_level[1:0], exp_trig, exp_pulse}
  // Level selects: level0 -> source 0, level1 -> source 1, level2 -> source 4 (trigger-in).
  localparam int NVEC = 13;
  localparam logic [16:0] VEC [NVEC] = '{
    {4'b0001, 8'h00, 1'b0, 2'd1, 1'b0, 1'b0},
    {4'b0000, 8'h00, 1'b0, 2'd1, 1'b0, 1'b0},
    {4'b0010, 8'h00, 1'b0, 2'd2, 1'b0, 1'b0},
    {4'b1111, 8'h00, 1'b0, 2'd2, 1'b0, 1'b0},
    {4'b0000, 8'h40, 1'b0, 2'd2, 1'b1, 1'b1},
    {4'b0000, 8'h00, 1'b0, 2'd2, 1'b1, 1'b0},
    {4'b0011, 8'hFF, 1'b0, 2'd2, 1'b1, 1'b0},
    {4'b0000, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0},
    {4'b0010, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0},
    {4'b0011, 8'h00, 1'b0, 2'd1, 1'b0, 1'b0},
    {4'b0011, 8'h00, 1'b0, 2'd2, 1'b0, 1'b0},
    {4'b0000, 8'h01, 1'b1, 2'd0, 1'b0, 1'b0},
    {4'b0001, 8'h00, 1'b0, 2'd1, 1'b0, 1'b0}
  };
  string vtag [NVEC] = '{"R2", "R2", "R2", "R2", "R5", "R5", "R7",
                         "R8", "R4", "R3", "R3", "R8", "R2"};

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    sel = {3'd4, 3'd1, 3'd0};
    repeat (3) @(negedge clk);
    // R1 during reset
    check_main("R1", 0, 0, 0);
    check("R1", "direct trig_o", d_trig, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 first cycle after release
    check_main("R1", 0, 0, 0);

    for (int i = 0; i < NVEC; i++) begin
      {match, tin, arm} = VEC[i][16:4];
      @(negedge clk);
      check_main(vtag[i], int'(VEC[i][3:2]), int'(VEC[i][1]), int'(VEC[i][0]));
    end

    // Return to level 0
    {match, tin, arm} = {4'b0000, 8'h00, 1'b1};
    @(negedge clk);
    check_main("R8", 0, 0, 0);

    // R10: out-of-range select code on level 0
    sel = {3'd4, 3'd1, 3'd7};
    {match, tin, arm} = {4'b1111, 8'hFF, 1'b0};
    @(negedge clk);
    check_main("R10", 0, 0, 0);
    @(negedge clk);
    check_main("R10", 0, 0, 0);

    // R9: a single high trigger-in bit completes the last level
    sel = {3'd4, 3'd1, 3'd0};
    {match, tin, arm} = {4'b0001, 8'h00, 1'b0};
    @(negedge clk);
    {match, tin, arm} = {4'b0010, 8'h00, 1'b0};
    @(negedge clk);
    check_main("R9", 2, 0, 0);
    {match, tin, arm} = {4'b0000, 8'h80, 1'b0};
    @(negedge clk);
    check_main("R9", 2, 1, 1);
    {match, tin, arm} = '0;

    // R11: zero-level build fires on any source; R6: no trigger-out
    d_match = 4'b0100;
    @(negedge clk);
    check("R11", "direct trig_o", d_trig, 1);
    check("R11", "direct trig_pulse_o", d_pulse, 1);
    check("R6", "direct trig_out_o", d_tout, 0);
    check("R11", "direct level_o", d_lvl, 0);
    d_match = 4'b1000;
    @(negedge clk);
    check("R11", "direct held trig_o", d_trig, 1);
    check("R11", "direct no repeat pulse", d_pulse, 0);
    d_match = 4'b0000;
    d_arm = 1'b1;
    @(negedge clk);
    check("R11", "direct rearmed trig_o", d_trig, 0);
    d_arm = 1'b0;
    @(negedge clk);
    check("R11", "direct idle trig_o", d_trig, 0);

    summary();
    $finish;
  end

endmodule